// File: doc/BRIEF.md
# Idle Activity Monitor with SMI Trap

This block helps firmware manage peripheral power without operating-system help. It receives decoded accesses from the bus as a valid strobe and a device index, and marks each access in a per-device activity register. Firmware clears that register by writing ones. A prescaled timer can raise a system management interrupt (SMI) once per period of nominally one minute. On each tick firmware reads the activity bits to decide whether the machine has been idle.

When firmware has powered a device down, it arms a trap for that device. A later software access to an armed device is not forwarded. Instead it is recorded as a trap cause and the SMI line rises. Firmware can then wake the device, disarm the trap and restart the access. The cause register keeps the timer tick and each trapped device in separate bits, all write-one-to-clear. The SMI output stays high while any cause bit is set.

Device indices: 0 serial port, 1 parallel port, 2 floppy controller, 3 keyboard controller, 4 audio. Register addresses: 0 control, 1 activity, 2 trap arm, 3 cause.

Top module: `idle_smi_monitor`

## Requirements
- R1: When control bit 0 (address 0) is 1, cause bit 0 (address 3) is set TICK_PERIOD cycles after the enabling write takes effect, and again every TICK_PERIOD cycles while the bit stays enabled.
- R2: When control bit 0 is 0, the prescaler is held at zero and no tick occurs. After re-enabling, the first tick again takes a full TICK_PERIOD cycles.
- R3: An access with acc_dev = d < NUM_DEV sets activity bit d (address 1) one clock later. An index at or above NUM_DEV records nothing and is forwarded.
- R4: A write to address 1 clears each activity bit written with 1 and leaves every bit written with 0 unchanged.
- R5: When an access sets an activity bit in the same cycle that a write clears it, the bit ends up set.
- R6: When trap-arm bit d (address 2) is 1, an access to device d drives acc_fwd low in that cycle. Cause bit d+1 is set one clock later, and activity bit d is also set.
- R7: When trap-arm bit d is 0, an access to device d drives acc_fwd high and sets no cause bit.
- R8: smi is high while any cause bit is set. Writing ones to address 3 clears those cause bits, and smi falls once no cause bit remains.
- R9: After reset, all four registers read zero, smi is low and the timer is disabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for both read and write |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| acc_valid | input | 1 | Decoded peripheral access strobe |
| acc_dev | input | DEV_ID_W | Index of the device being accessed |
| acc_fwd | output | 1 | High when the current access may proceed to the device |
| smi | output | 1 | System management interrupt request |

## Verification
Two pairs of events can fall in the same cycle. A bus access can set an activity bit while a write-one-to-clear to that bit is being accepted. A trapped access can also arrive while firmware is clearing causes. The bench provokes the first pair by driving the access strobe and the clearing write on the same clock edge. It then reads the activity register back and expects the bit to remain set. Timer ticks are judged by sampling the cause register one cycle before and at the exact cycle where the tick must land, both after a fresh enable and after a disable partway through a period.

// File: rtl/idle_smi_pkg.sv
package idle_smi_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_ACT   = 2'd1;
  localparam logic [1:0] ADDR_TRAP  = 2'd2;
  localparam logic [1:0] ADDR_CAUSE = 2'd3;

  // Next value of a write-one-to-clear bank: new events win over clears.
  function automatic logic [31:0] w1c_next(input logic [31:0] cur,
                                           input logic [31:0] set_v,
                                           input logic [31:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  // Prescaler terminal count.
  function automatic logic tick_due(input logic [31:0] cnt,
                                    input logic [31:0] period);
    return cnt == (period - 32'd1);
  endfunction

endpackage

// File: rtl/smi_tick_gen.sv
module smi_tick_gen #(
  parameter int PERIOD = 6000,
  localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  import idle_smi_pkg::*;

  logic [CW-1:0] cnt_q;
  logic          due;

  assign due  = tick_due(32'(cnt_q), 32'(PERIOD));
  assign tick = en && due;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en)    cnt_q <= '0;
    else if (due)    cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/smi_w1c_bank.sv
module smi_w1c_bank #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  import idle_smi_pkg::*;

  logic [31:0] nxt;

  assign nxt = w1c_next(32'(q), 32'(set_vec), clr_en ? 32'(clr_vec) : 32'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
  end
endmodule

// File: rtl/smi_access_trap.sv
module smi_access_trap #(
  parameter int NUM_DEV = 5,
  parameter int IDW = 3
) (
  input  logic               acc_valid,
  input  logic [IDW-1:0]     acc_dev,
  input  logic [NUM_DEV-1:0] trap_en,
  output logic [NUM_DEV-1:0] hit,
  output logic [NUM_DEV-1:0] trapped,
  output logic               fwd
);
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    assign hit[g]     = acc_valid && (acc_dev == IDW'(g));
    assign trapped[g] = hit[g] && trap_en[g];
  end

  assign fwd = acc_valid && !(|trapped);
endmodule

// File: rtl/idle_smi_monitor.sv
module idle_smi_monitor #(
  parameter int NUM_DEV = 5,
  parameter int TICK_PERIOD = 6000,
  parameter int DATA_W = 32,
  localparam int DEV_ID_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                acc_valid,
  input  logic [DEV_ID_W-1:0] acc_dev,
  output logic                acc_fwd,
  output logic                smi
);
  import idle_smi_pkg::*;

  localparam int CAUSE_W = NUM_DEV + 1;

  logic               tick_en_q;
  logic [NUM_DEV-1:0] trap_en_q;
  logic [NUM_DEV-1:0] act_q;
  logic [CAUSE_W-1:0] cause_q;

  // Named internal events
  logic               tick_fire;
  logic [NUM_DEV-1:0] act_hit;
  logic [NUM_DEV-1:0] trap_hit;
  logic               wr_act_clr;
  logic               wr_cause_clr;

  assign wr_act_clr   = reg_wr && (reg_addr == ADDR_ACT);
  assign wr_cause_clr = reg_wr && (reg_addr == ADDR_CAUSE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_en_q <= 1'b0;
      trap_en_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADDR_CTRL) tick_en_q <= reg_wdata[0];
      if (reg_addr == ADDR_TRAP) trap_en_q <= reg_wdata[NUM_DEV-1:0];
    end
  end

  smi_tick_gen #(.PERIOD(TICK_PERIOD)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (tick_en_q),
    .tick (tick_fire)
  );

  smi_access_trap #(.NUM_DEV(NUM_DEV), .IDW(DEV_ID_W)) u_trap (
    .acc_valid(acc_valid),
    .acc_dev  (acc_dev),
    .trap_en  (trap_en_q),
    .hit      (act_hit),
    .trapped  (trap_hit),
    .fwd      (acc_fwd)
  );

  smi_w1c_bank #(.W(NUM_DEV)) u_act (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(act_hit),
    .clr_en (wr_act_clr),
    .clr_vec(reg_wdata[NUM_DEV-1:0]),
    .q      (act_q)
  );

  smi_w1c_bank #(.W(CAUSE_W)) u_cause (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec({trap_hit, tick_fire}),
    .clr_en (wr_cause_clr),
    .clr_vec(reg_wdata[CAUSE_W-1:0]),
    .q      (cause_q)
  );

  assign smi = |cause_q;

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL:  reg_rdata[0]           = tick_en_q;
      ADDR_ACT:   reg_rdata[NUM_DEV-1:0] = act_q;
      ADDR_TRAP:  reg_rdata[NUM_DEV-1:0] = trap_en_q;
      default:    reg_rdata[CAUSE_W-1:0] = cause_q;
    endcase
  end
endmodule

// File: rtl/idle_smi_checker.sv
module idle_smi_checker #(
  parameter int NUM_DEV = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr,
  input logic               acc_valid,
  input logic               acc_fwd,
  input logic               smi,
  input logic               tick_en,
  input logic               tick_fire,
  input logic               wr_act_clr,
  input logic [NUM_DEV-1:0] act_hit,
  input logic [NUM_DEV-1:0] trap_hit,
  input logic [NUM_DEV-1:0] trap_en,
  input logic [NUM_DEV-1:0] act_q,
  input logic [NUM_DEV:0]   cause_q
);
  a_r1_tick_records: assert property (@(posedge clk) disable iff (!rst_n)
    tick_fire |=> cause_q[0]);

  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |-> !tick_fire);

  a_r3_activity_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (|act_hit) |=> ((act_q & $past(act_hit)) == $past(act_hit)));

  a_r5_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_act_clr && (|act_hit)) |=> ((act_q & $past(act_hit)) == $past(act_hit)));

  a_r6_trap_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (|(act_hit & trap_en)) |-> !acc_fwd);

  a_r6_trap_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (|trap_hit) |=> ((cause_q[NUM_DEV:1] & $past(trap_hit)) == $past(trap_hit)));

  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !(|(act_hit & trap_en))) |-> acc_fwd);

  a_r8_smi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cause_q) && !reg_wr) |=> smi);
endmodule

bind idle_smi_monitor idle_smi_checker #(.NUM_DEV(NUM_DEV)) u_idle_smi_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_wr    (reg_wr),
  .acc_valid (acc_valid),
  .acc_fwd   (acc_fwd),
  .smi       (smi),
  .tick_en   (tick_en_q),
  .tick_fire (tick_fire),
  .wr_act_clr(wr_act_clr),
  .act_hit   (act_hit),
  .trap_hit  (trap_hit),
  .trap_en   (trap_en_q),
  .act_q     (act_q),
  .cause_q   (cause_q)
);

// File: tb/test_idle_smi_monitor.sv
`timescale 1ns/100ps
module test_idle_smi_monitor;
  localparam int ND = 5;
  localparam int P  = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        acc_valid = 1'b0;
  logic [2:0]  acc_dev = '0;
  logic        acc_fwd;
  logic        smi;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 register read, 1 smi, 2 acc_fwd
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  idle_smi_monitor #(.NUM_DEV(ND), .TICK_PERIOD(P)) i_idle_smi_monitor (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
    .acc_dev(acc_dev), .acc_fwd(acc_fwd), .smi(smi)
  );

  // Monitor: pops expected items and compares against the ports.
  initial begin
    forever begin
      wait (sb_q.size() > 0);
      #0.5;
      begin
        item_t it;
        logic [31:0] got;
        it = sb_q.pop_front();
        got = (it.kind == 0) ? reg_rdata : (it.kind == 1) ? 32'(smi) : 32'(acc_fwd);
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  // Driver side: push an expectation, let the monitor consume it.
  task automatic expect_item(input int kind, input logic [1:0] a,
                             input logic [31:0] e, input string tag);
    item_t it;
    if (kind == 0) reg_addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    #1;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    expect_item(0, a, e, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic access(input logic [2:0] d, input logic efwd, input string tag);
    @(negedge clk);
    acc_valid = 1'b1; acc_dev = d;
    expect_item(2, 2'd0, 32'(efwd), tag);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9 reset state
    rd(2'd0, 32'h0, "R9 ctrl");
    rd(2'd1, 32'h0, "R9 act");
    rd(2'd2, 32'h0, "R9 trap");
    rd(2'd3, 32'h0, "R9 cause");
    @(negedge clk); expect_item(1, 2'd0, 32'd0, "R9 smi");

    // R3 activity recording, R7 forwarding while disarmed
    access(3'd0, 1'b1, "R7 serial fwd");
    rd(2'd1, 32'h01, "R3 serial act");
    access(3'd4, 1'b1, "R7 audio fwd");
    rd(2'd1, 32'h11, "R3 audio act");
    access(3'd6, 1'b1, "R3 out-of-range fwd");
    rd(2'd1, 32'h11, "R3 out-of-range act");
    rd(2'd3, 32'h00, "R7 no cause");

    // R4 write-one-to-clear
    wr(2'd1, 32'h01);
    rd(2'd1, 32'h10, "R4 clear bit0");
    wr(2'd1, 32'h00);
    rd(2'd1, 32'h10, "R4 zero write");
    wr(2'd1, 32'h10);
    rd(2'd1, 32'h00, "R4 clear bit4");

    // R5 access and clear on the same edge
    @(negedge clk);
    acc_valid = 1'b1; acc_dev = 3'd2;
    reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h04;
    @(negedge clk);
    acc_valid = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
    rd(2'd1, 32'h04, "R5 set wins");
    wr(2'd1, 32'h04);
    rd(2'd1, 32'h00, "R4 clear after collision");

    // R6 armed trap on keyboard (device 3)
    wr(2'd2, 32'h08);
    rd(2'd2, 32'h08, "R6 trap armed");
    access(3'd3, 1'b0, "R6 blocked");
    rd(2'd3, 32'h10, "R6 cause bit");
    rd(2'd1, 32'h08, "R6 activity too");
    expect_item(1, 2'd0, 32'd1, "R8 smi high");
    access(3'd1, 1'b1, "R7 other device fwd");
    rd(2'd3, 32'h10, "R7 cause unchanged");

    // R8 clearing causes drops smi
    wr(2'd3, 32'h10);
    rd(2'd3, 32'h00, "R8 cause cleared");
    expect_item(1, 2'd0, 32'd0, "R8 smi low");
    wr(2'd1, 32'h1f);

    // R7 disarmed trap passes through
    wr(2'd2, 32'h00);
    access(3'd3, 1'b1, "R7 disarmed fwd");
    rd(2'd3, 32'h00, "R7 disarmed no cause");

    // R1 tick lands exactly TICK_PERIOD cycles after enabling
    wr(2'd0, 32'h1);
    repeat (P - 1) @(negedge clk);
    expect_item(0, 2'd3, 32'h0, "R1 before tick");
    @(negedge clk);
    expect_item(0, 2'd3, 32'h1, "R1 tick");
    expect_item(1, 2'd0, 32'd1, "R8 smi on tick");
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h1);
    rd(2'd3, 32'h0, "R8 tick cleared");

    // R2 disable partway, then full period after re-enable
    wr(2'd0, 32'h1);
    repeat (P / 2) @(negedge clk);
    wr(2'd0, 32'h0);
    repeat (P) @(negedge clk);
    expect_item(0, 2'd3, 32'h0, "R2 no tick while off");
    wr(2'd0, 32'h1);
    repeat (P - 1) @(negedge clk);
    expect_item(0, 2'd3, 32'h0, "R2 no early tick");
    @(negedge clk);
    expect_item(0, 2'd3, 32'h1, "R2 full period");
    wr(2'd0, 32'h0);

    wait (sb_q.size() == 0);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule